// File: doc/BRIEF.md
# Serial Line Transmitter with Break Generation

This block turns queued words into an asynchronous serial bit stream. Software-side logic writes words, each with an optional ninth flag bit, into a small FIFO. When the transmitter is idle and enabled, it takes the oldest word and sends a frame on `txd`: a start bit, the data bits least significant first, an optional ninth bit, and then a configurable stop period. All timing comes from an external oversample tick. Sixteen ticks make one bit period.

The frame format selects 8 data bits, 7 data bits, 8 bits with odd or even parity, or 8 bits with a caller-supplied ninth flag. The stop-period selector sets the sent stop length to one, one and a half, or two bit times. A one-shot break request makes the next transmission a sync break: 13 bit times at the active level, followed by one idle bit time. The request is then cleared by the hardware. A level override input pins the line to the active level, and an inversion input flips the whole output, idle level included.

Clearing the enable puts the framing logic back to idle at once. The words still in the FIFO, and a pending break request, are kept.

Top module: `sertx_top`

## Requirements
- R1: With `inv_out`=0 the idle `txd` is 1 and frame bits appear as sent. With `inv_out`=1 every level on `txd` is inverted, so idle is 0.
- R2: A frame is a start bit (line 0) followed by data bits sent least significant first, each bit lasting 16 ticks. `frame_fmt` 3'd0 sends 8 bits and 3'd1 sends the low 7 bits. Codes 5 to 7 behave as 3'd0.
- R3: The ninth bit follows the data. For `frame_fmt` 3'd2 it is odd parity (total ones odd). For 3'd3 it is even parity. For 3'd4 it is `wr_flag` as written with the word.
- R4: The stop period is at line level 1. Its length is 16 ticks for `stop_sel` 2'b00, 24 ticks for 2'b01, and 32 ticks for 2'b10 and 2'b11.
- R5: After a `brk_req` pulse, `brk_pending` is 1. The next transmission with a word queued is 13 bit times at line level 0, then 16 ticks at 1. `brk_pending` then returns to 0, and the queued word follows as a normal frame.
- R6: While `line_force` is 1, `txd` equals `inv_out` (the active level), whatever the framing logic is doing.
- R7: While `tx_en` is 0, nothing is sent: `busy` is 0 and `txd` is idle. Dropping `tx_en` mid-frame ends the frame on the next cycle. Words left in the FIFO are kept and are sent once `tx_en` returns.
- R8: `busy` is 1 from the first cycle of the start bit (or break) to the last cycle of the stop period. A new word is taken only when the transmitter is idle, so busy time per frame is 16×(1+bits)+stop ticks.
- R9: `fifo_full` is 1 when DEPTH (4) words are stored. A write while full is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| baud_tick | input | 1 | Oversample tick, 16 per bit |
| tx_en | input | 1 | Transmit enable |
| frame_fmt | input | 3 | Frame format code |
| stop_sel | input | 2 | Stop period selector |
| inv_out | input | 1 | Output polarity inversion |
| line_force | input | 1 | Hold line at active level |
| brk_req | input | 1 | One-cycle request to send a break |
| wr_en | input | 1 | FIFO write strobe |
| wr_data | input | 8 | Word to send |
| wr_flag | input | 1 | Ninth bit for format 3'd4 |
| fifo_full | output | 1 | FIFO holds DEPTH words |
| busy | output | 1 | Frame or break in progress |
| brk_pending | output | 1 | Break request not yet completed |
| txd | output | 1 | Serial output |

## Verification
The hardest situations to reach are those where enable or override state changes against a frame already in progress. One case is dropping `tx_en` halfway through a character while a second word waits, then showing that the second word still goes out intact. The other is a break that must sit between two queued words. The stimulus reaches the first case by filling the FIFO while disabled, enabling, and removing the enable a fixed number of cycles after `busy` rises. The expected items for the cut frame and the surviving word are queued beforehand. For the break case, the request is pulsed before the word is written, so the scoreboard expects a break item and then a character item.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_BRK, ST_START, ST_DATA, ST_NINTH, ST_STOP
  } tx_state_e;

  localparam logic [2:0] FMT_8   = 3'd0;
  localparam logic [2:0] FMT_7   = 3'd1;
  localparam logic [2:0] FMT_ODD = 3'd2;
  localparam logic [2:0] FMT_EVN = 3'd3;
  localparam logic [2:0] FMT_9   = 3'd4;

  function automatic logic fmt_is_short(input logic [2:0] f);
    return f == FMT_7;
  endfunction

  function automatic logic fmt_has_ninth(input logic [2:0] f);
    return (f == FMT_ODD) || (f == FMT_EVN) || (f == FMT_9);
  endfunction

  function automatic logic ninth_value(input logic [2:0] f, input logic [7:0] d,
                                       input logic flag);
    case (f)
      FMT_ODD: return ~^d;
      FMT_EVN: return ^d;
      default: return flag;
    endcase
  endfunction

endpackage

// File: rtl/sertx_fifo.sv
module sertx_fifo #(
  parameter int DEPTH = 4,
  parameter int W     = 9
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] wdata,
  input  logic         pop,
  output logic [W-1:0] rdata,
  output logic         empty,
  output logic         full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] rd_q, wr_q, rd_d, wr_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          do_push, do_pop;

  assign empty   = (cnt_q == '0);
  assign full    = (cnt_q == CW'(DEPTH));
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign rdata   = mem[rd_q];

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    rd_d  = do_pop  ? bump(rd_q) : rd_q;
    wr_d  = do_push ? bump(wr_q) : wr_q;
    cnt_d = cnt_q + CW'(do_push) - CW'(do_pop);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
    end else begin
      rd_q  <= rd_d;
      wr_q  <= wr_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_q] <= wdata;
  end

  p_full_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push && !pop) |=> (full && $stable(wr_q)));

endmodule

// File: rtl/sertx_fsm.sv
module sertx_fsm
  import sertx_pkg::*;
#(
  parameter int OSR      = 16,
  parameter int BRK_BITS = 13,
  parameter int DW       = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          tx_en,
  input  logic [2:0]    fmt,
  input  logic [1:0]    stop_sel,
  input  logic          brk_req,
  input  logic          q_empty,
  input  logic [DW:0]   q_word,
  output logic          q_pop,
  output logic          line,
  output logic          busy,
  output logic          brk_pend
);
  localparam int TW = $clog2(2 * OSR + 1);
  localparam int BW = $clog2((BRK_BITS > DW ? BRK_BITS : DW) + 1);

  tx_state_e     st_q, st_d;
  logic [TW-1:0] tc_q, tc_d, tlim;
  logic [BW-1:0] bc_q, bc_d;
  logic [DW-1:0] sh_q, sh_d;
  logic          nb_q, nb_d, hn_q, hn_d, bm_q, bm_d, bp_q, bp_d;
  logic          bit_end;

  always_comb begin
    tlim = TW'(OSR);
    if (st_q == ST_STOP && !bm_q) begin
      case (stop_sel)
        2'b00:   tlim = TW'(OSR);
        2'b01:   tlim = TW'(OSR + OSR / 2);
        default: tlim = TW'(2 * OSR);
      endcase
    end
  end

  assign bit_end = tick && (tc_q == tlim - 1'b1);

  always_comb begin
    st_d  = st_q;  tc_d = tc_q;  bc_d = bc_q;  sh_d = sh_q;
    nb_d  = nb_q;  hn_d = hn_q;  bm_d = bm_q;
    bp_d  = bp_q | brk_req;
    q_pop = 1'b0;
    if (tick) tc_d = tc_q + 1'b1;
    if (bit_end) tc_d = '0;
    case (st_q)
      ST_IDLE: begin
        tc_d = '0;
        if (!q_empty) begin
          if (bp_q) begin
            st_d = ST_BRK;
            bc_d = BW'(BRK_BITS - 1);
            bm_d = 1'b1;
          end else begin
            q_pop = 1'b1;
            st_d  = ST_START;
            sh_d  = q_word[DW-1:0];
            bc_d  = fmt_is_short(fmt) ? BW'(DW - 2) : BW'(DW - 1);
            hn_d  = fmt_has_ninth(fmt);
            nb_d  = ninth_value(fmt, q_word[DW-1:0], q_word[DW]);
          end
        end
      end
      ST_BRK: if (bit_end) begin
        if (bc_q == '0) st_d = ST_STOP;
        else            bc_d = bc_q - 1'b1;
      end
      ST_START: if (bit_end) st_d = ST_DATA;
      ST_DATA: if (bit_end) begin
        sh_d = sh_q >> 1;
        if (bc_q == '0) st_d = hn_q ? ST_NINTH : ST_STOP;
        else            bc_d = bc_q - 1'b1;
      end
      ST_NINTH: if (bit_end) st_d = ST_STOP;
      ST_STOP: if (bit_end) begin
        st_d = ST_IDLE;
        if (bm_q) begin
          bm_d = 1'b0;
          bp_d = brk_req;
        end
      end
      default: st_d = ST_IDLE;
    endcase
    if (!tx_en) begin
      st_d  = ST_IDLE;
      tc_d  = '0;
      bm_d  = 1'b0;
      q_pop = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE;
      tc_q <= '0;
      bc_q <= '0;
      sh_q <= '0;
      nb_q <= 1'b0;
      hn_q <= 1'b0;
      bm_q <= 1'b0;
      bp_q <= 1'b0;
    end else begin
      st_q <= st_d;
      tc_q <= tc_d;
      bc_q <= bc_d;
      sh_q <= sh_d;
      nb_q <= nb_d;
      hn_q <= hn_d;
      bm_q <= bm_d;
      bp_q <= bp_d;
    end
  end

  always_comb begin
    case (st_q)
      ST_BRK, ST_START: line = 1'b0;
      ST_DATA:          line = sh_q[0];
      ST_NINTH:         line = nb_q;
      default:          line = 1'b1;
    endcase
  end

  assign busy     = (st_q != ST_IDLE);
  assign brk_pend = bp_q;

  p_idle_line_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> line);
  p_brk_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bp_q && st_q == ST_BRK) |=> bp_q);
  p_disable_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en |=> !busy);
  p_end_in_stop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(busy) && $past(tx_en)) |-> ($past(st_q) == ST_STOP));

endmodule

// File: rtl/sertx_top.sv
module sertx_top #(
  parameter int DEPTH    = 4,
  parameter int OSR      = 16,
  parameter int BRK_BITS = 13,
  parameter int DW       = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          baud_tick,
  input  logic          tx_en,
  input  logic [2:0]    frame_fmt,
  input  logic [1:0]    stop_sel,
  input  logic          inv_out,
  input  logic          line_force,
  input  logic          brk_req,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          wr_flag,
  output logic          fifo_full,
  output logic          busy,
  output logic          brk_pending,
  output logic          txd
);
  localparam int WW = DW + 1;

  logic [WW-1:0] q_word;
  logic          q_empty, q_pop, line;

  sertx_fifo #(.DEPTH(DEPTH), .W(WW)) u_fifo (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (wr_en),
    .wdata ({wr_flag, wr_data}),
    .pop   (q_pop),
    .rdata (q_word),
    .empty (q_empty),
    .full  (fifo_full)
  );

  sertx_fsm #(.OSR(OSR), .BRK_BITS(BRK_BITS), .DW(DW)) u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (baud_tick),
    .tx_en    (tx_en),
    .fmt      (frame_fmt),
    .stop_sel (stop_sel),
    .brk_req  (brk_req),
    .q_empty  (q_empty),
    .q_word   (q_word),
    .q_pop    (q_pop),
    .line     (line),
    .busy     (busy),
    .brk_pend (brk_pending)
  );

  assign txd = line_force ? inv_out : (line ^ inv_out);

  p_force_active_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (line_force && $stable(inv_out)) |=> (txd == inv_out || !line_force));
  p_idle_polarity_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !line_force) |-> (txd == !inv_out));

endmodule

// File: tb/tb_sertx_top.sv
module tb_sertx_top;
  typedef struct {
    int         kind;   // 0 char, 1 break, 2 cut, 3 forced
    int         nb;
    logic [8:0] bits;
    int         dur;
    string      tag;
  } item_t;

  logic clk = 0, rst_n = 0;
  logic tx_en = 0, inv_out = 0, line_force = 0, brk_req = 0;
  logic wr_en = 0, wr_flag = 0;
  logic [2:0] frame_fmt = 0;
  logic [1:0] stop_sel = 0;
  logic [7:0] wr_data = 0;
  logic fifo_full, busy, brk_pending, txd;
  int n_chk = 0, n_fail = 0;
  item_t q[$];

  always #10 clk = ~clk;

  sertx_top dut (
    .clk(clk), .rst_n(rst_n), .baud_tick(1'b1), .tx_en(tx_en),
    .frame_fmt(frame_fmt), .stop_sel(stop_sel), .inv_out(inv_out),
    .line_force(line_force), .brk_req(brk_req), .wr_en(wr_en),
    .wr_data(wr_data), .wr_flag(wr_flag), .fifo_full(fifo_full),
    .busy(busy), .brk_pending(brk_pending), .txd(txd)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int stop_len(input logic [1:0] s);
    return (s == 2'b00) ? 16 : (s == 2'b01) ? 24 : 32;
  endfunction

  task automatic push_word(input logic [7:0] d, input logic f);
    @(negedge clk); wr_en = 1; wr_data = d; wr_flag = f;
    @(negedge clk); wr_en = 0;
  endtask

  // Driver: computes the expected frame from the requirements, then writes.
  task automatic send(input logic [7:0] d, input logic f, input int kind, input string tag);
    item_t it;
    int nd = (frame_fmt == 3'd1) ? 7 : 8;
    logic nine;
    it.kind = kind; it.tag = tag;
    it.bits = {1'b0, d};
    if (frame_fmt == 3'd2) nine = ~^d;
    else if (frame_fmt == 3'd3) nine = ^d;
    else nine = f;
    it.nb = nd;
    if (frame_fmt >= 3'd2 && frame_fmt <= 3'd4) begin
      it.bits[nd] = nine; it.nb = nd + 1;
    end
    it.dur = 16 * (1 + it.nb) + stop_len(stop_sel);
    q.push_back(it);
    push_word(d, f);
  endtask

  task automatic drain();
    wait (q.size() == 0);
    @(negedge clk);
    while (busy) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  // Monitor: pops one expected item per busy interval and compares.
  initial begin
    item_t it;
    int c;
    logic n;
    forever begin
      @(negedge clk);
      if (busy && rst_n) begin
        if (q.size() == 0) begin
          chk("R8 unexpected frame", 1, 0);
          while (busy) @(negedge clk);
        end else begin
          it = q.pop_front();
          c = 0;
          while (busy) begin
            n = txd ^ inv_out;
            if (it.kind == 3) begin
              if (c % 16 == 8) chk("R6 forced level", txd, inv_out);
            end else if (it.kind == 1) begin
              if (c == 8) begin
                chk("R5 break low", n, 0);
                chk("R5 pending during break", brk_pending, 1);
              end
              if (c == 13 * 16 - 8) chk("R5 break end low", n, 0);
              if (c == 13 * 16 + 8) chk("R5 break idle bit", n, 1);
            end else if (it.kind == 0) begin
              if (c == 8) chk({it.tag, " start R2"}, n, 0);
              if (c % 16 == 8 && c / 16 >= 1 && c / 16 <= it.nb)
                chk((c / 16 == 9) ? {it.tag, " ninth R3"} : {it.tag, " data R2"},
                    n, it.bits[c / 16 - 1]);
              if (c == 16 * (1 + it.nb) + 4) chk({it.tag, " stop R4"}, n, 1);
            end
            c++;
            @(negedge clk);
          end
          if (it.kind == 1) begin
            chk("R5 break length", c, 224);
            chk("R5 pending cleared", brk_pending, 0);
          end else if (it.kind == 2) begin
            chk("R7 cut frame idle", txd ^ inv_out, 1);
            chk("R7 cut early", c < it.dur, 1);
          end else begin
            chk({it.tag, " busy length R4 R8"}, c, it.dur);
          end
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    item_t bi;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 reset idle", txd, 1);
    chk("R8 reset busy", busy, 0);
    chk("R9 reset full", fifo_full, 0);
    chk("R5 reset pending", brk_pending, 0);

    tx_en = 1;
    send(8'hA5, 0, 0, "R2 fmt8");
    send(8'h3C, 0, 0, "R2 fmt8 b2b");
    drain();
    frame_fmt = 3'd1;
    send(8'hD5, 0, 0, "R2 fmt7");
    drain();
    frame_fmt = 3'd2; stop_sel = 2'b01;
    send(8'h07, 0, 0, "R3 odd");
    send(8'h00, 0, 0, "R3 odd zero");
    drain();
    frame_fmt = 3'd3; stop_sel = 2'b10;
    send(8'h07, 0, 0, "R3 even");
    drain();
    stop_sel = 2'b11;
    send(8'h81, 0, 0, "R3 even s11");
    drain();
    frame_fmt = 3'd4; stop_sel = 2'b00;
    send(8'h12, 1, 0, "R3 flag1");
    send(8'h12, 0, 0, "R3 flag0");
    drain();
    frame_fmt = 3'd0; inv_out = 1;
    repeat (2) @(negedge clk);
    chk("R1 inverted idle", txd, 0);
    send(8'h96, 0, 0, "R1 inverted frame");
    drain();
    inv_out = 0;

    // R5: break before the next queued word
    @(negedge clk); brk_req = 1;
    @(negedge clk); brk_req = 0;
    chk("R5 pending set", brk_pending, 1);
    bi.kind = 1; bi.nb = 0; bi.bits = 0; bi.dur = 224; bi.tag = "R5";
    q.push_back(bi);
    send(8'h5A, 0, 0, "R5 after break");
    drain();

    // R6: level override, idle and across a frame
    line_force = 1;
    @(negedge clk); chk("R6 force idle normal", txd, 0);
    inv_out = 1;
    @(negedge clk); chk("R6 force idle inverted", txd, 1);
    inv_out = 0;
    send(8'hFF, 0, 3, "R6");
    drain();
    line_force = 0;
    @(negedge clk); chk("R6 release", txd, 1);

    // R7/R9: fill while disabled, overflow dropped
    tx_en = 0;
    send(8'h11, 0, 0, "R9 w0");
    send(8'h22, 0, 0, "R9 w1");
    send(8'h33, 0, 0, "R9 w2");
    send(8'h44, 0, 0, "R9 w3");
    chk("R9 full", fifo_full, 1);
    push_word(8'h55, 0);
    repeat (40) @(negedge clk);
    chk("R7 disabled busy", busy, 0);
    chk("R7 disabled idle", txd, 1);
    tx_en = 1;
    drain();
    chk("R9 dropped word", q.size(), 0);

    // R7: cut a frame mid-way, the queued word survives
    tx_en = 0;
    send(8'hC3, 0, 2, "R7 cut");
    send(8'h69, 0, 0, "R7 survivor");
    tx_en = 1;
    wait (busy);
    repeat (40) @(negedge clk);
    tx_en = 0;
    @(negedge clk);
    chk("R7 stop on disable", busy, 0);
    repeat (20) @(negedge clk);
    chk("R7 stays idle", busy, 0);
    tx_en = 1;
    drain();

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule